// File: doc/BRIEF.md
# Mandelbrot Escape Solver

This block is one worker in a bank of identical escape-time engines that together render a Mandelbrot frame. The frame is scanned in raster order. Each worker owns every N-th pixel, counting from its own ID. For each pixel it owns, the worker forms the complex coordinate from a top-left corner and separate horizontal and vertical step sizes. It then iterates z = z² + c in signed fixed point and stores the escape count in its own result memory. The results are packed: the k-th owned pixel lands at address k.

The datapath has only two signed multipliers, and they are shared across three compute cycles per iteration. In the first cycle the adds and the escape test happen. The second cycle forms both squares. The third reuses one multiplier for the real-by-imaginary product, which is only consumed in the next first cycle. Coordinates are stepped by additions while the worker walks the frame, so no axis table and no coordinate multiply are needed. Points that fall inside one of two fixed rectangles deep in the main cardioid and the period-2 bulb take the maximum count at once. A display side reads the memory through a registered read port once `done` is high.

Top module: `mandel_solver`

## Requirements
- R1: A one-cycle `start` latches `x0`, `y0`, `zoom_x`, `zoom_y`, `solver_id` and `solver_cnt`, clears `done` and restarts the write address at 0. Changes on those inputs after the start cycle have no effect on the results of that frame.
- R2: Pixel index p = row·H_RES + col. The worker handles exactly the pixels with p mod `solver_cnt` = `solver_id` (`solver_cnt` of 0 acts as 1). It writes their results in increasing p to consecutive addresses 0, 1, 2, …
- R3: The coordinate of pixel (col,row) is c = (x0 + col·zoom_x, y0 + row·zoom_y), each part wrapped to W bits.
- R4: Numbers are two's complement with FRAC fraction bits (default Q4.23, W = 27). z starts at 0. Each step sets zr ← wrapW(sr − si + cr) and zi ← wrapW(2·x + ci). Here sr = ⌊zr²/2^FRAC⌋ and si = ⌊zi²/2^FRAC⌋ are kept at 2W−FRAC bits, and x = wrapW(⌊zr·zi/2^FRAC⌋).
- R5: The result is the smallest k ≥ 1 for which sr + si of z_k exceeds 4·2^FRAC. If no such k ≤ MAX_ITER exists, the result is MAX_ITER.
- R6: If cr ∈ [−0.5, 0.125] and ci ∈ [−0.375, 0.375], or if cr ∈ [−1.125, −0.875] and ci ∈ [−0.125, 0.125] (bounds inclusive), the result is MAX_ITER without iterating. Such a pixel finishes in a few cycles.
- R7: `done` is low from the cycle after `start` until the last owned pixel of the frame is written. It then stays high until the next `start`.
- R8: `rd_data` shows the memory word at `rd_addr` one clock after the address is applied.
- R9: The result width is ⌈log2(MAX_ITER+1)⌉ bits, and MAX_ITER defaults to 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new frame, latching the set-up inputs |
| x0 | input | W | Real part of the top-left corner |
| y0 | input | W | Imaginary part of the top-left corner |
| zoom_x | input | W | Real step per column |
| zoom_y | input | W | Imaginary step per row |
| solver_id | input | IDW | Index of this worker in the bank |
| solver_cnt | input | IDW | Number of workers in the bank |
| rd_addr | input | AW | Result memory read address |
| rd_data | output | CW | Escape count at the read address, one cycle later |
| done | output | 1 | Frame finished for this worker |

## Verification
Escape counts are only due once `done` rises. The number of cycles until then depends on the data, so the checks wait on `done` under a cycle bound instead of predicting the exact edge. After that, each read address is driven on a falling edge and `rd_data` is sampled on the next falling edge, one clock after the address, as R8 requires. `done` is checked low on the falling edge right after `start` and still high a few cycles after it rose. The rectangle early-out is confirmed through frame duration: a frame of rectangle pixels must finish within five cycles per pixel, while a frame one step outside a rectangle must take more than a hundred.

// File: rtl/mandel_pkg.sv
package mandel_pkg;

  // iteration core phases
  typedef enum logic [1:0] {
    CS_IDLE,
    CS_C1,   // adds, escape and rectangle tests
    CS_C2,   // both squares
    CS_C3    // cross product on the shared multiplier
  } core_state_e;

  // frame walk phases
  typedef enum logic [1:0] {
    TS_IDLE,
    TS_SCAN,
    TS_WAIT,
    TS_DONE
  } walk_state_e;

endpackage

// File: rtl/mandel_coord_walk.sv
module mandel_coord_walk #(
  parameter int W     = 27,
  parameter int H_RES = 640,
  parameter int V_RES = 480,
  parameter int IDW   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                adv,
  input  logic signed [W-1:0] x0,
  input  logic signed [W-1:0] y0,
  input  logic signed [W-1:0] zoom_x,
  input  logic signed [W-1:0] zoom_y,
  input  logic [IDW-1:0]      sid,
  input  logic [IDW-1:0]      scnt,
  output logic signed [W-1:0] cr,
  output logic signed [W-1:0] ci,
  output logic                owned,
  output logic                last
);

  localparam int CLW = $clog2(H_RES);
  localparam int RWW = $clog2(V_RES);

  logic [CLW-1:0]      col;
  logic [RWW-1:0]      row;
  logic [IDW-1:0]      slot, sid_q, scnt_q;
  logic signed [W-1:0] x0_q, zx_q, zy_q;
  logic                end_col, slot_wrap;

  assign end_col   = (col == CLW'(H_RES - 1));
  assign last      = end_col && (row == RWW'(V_RES - 1));
  assign owned     = (slot == sid_q);
  assign slot_wrap = ({1'b0, slot} + 1'b1) >= {1'b0, scnt_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      col    <= '0;
      row    <= '0;
      slot   <= '0;
      cr     <= '0;
      ci     <= '0;
      x0_q   <= '0;
      zx_q   <= '0;
      zy_q   <= '0;
      sid_q  <= '0;
      scnt_q <= '0;
    end else if (load) begin
      col    <= '0;
      row    <= '0;
      slot   <= '0;
      cr     <= x0;
      ci     <= y0;
      x0_q   <= x0;
      zx_q   <= zoom_x;
      zy_q   <= zoom_y;
      sid_q  <= sid;
      scnt_q <= scnt;
    end else if (adv) begin
      slot <= slot_wrap ? '0 : slot + 1'b1;
      if (end_col) begin
        col <= '0;
        row <= row + 1'b1;
        cr  <= x0_q;
        ci  <= ci + zy_q;
      end else begin
        col <= col + 1'b1;
        cr  <= cr + zx_q;
      end
    end
  end

endmodule

// File: rtl/mandel_iter_core.sv
module mandel_iter_core
  import mandel_pkg::*;
#(
  parameter int W        = 27,
  parameter int FRAC     = 23,
  parameter int MAX_ITER = 1000,
  parameter int CW       = $clog2(MAX_ITER + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                go,
  input  logic signed [W-1:0] cr,
  input  logic signed [W-1:0] ci,
  output logic                res_valid,
  output logic [CW-1:0]       res_cnt
);

  localparam int SW  = 2 * W - FRAC;
  localparam int ONE = 1 << FRAC;

  localparam logic signed [W-1:0] CRD_RE_LO = W'(-ONE / 2);
  localparam logic signed [W-1:0] CRD_RE_HI = W'(ONE / 8);
  localparam logic signed [W-1:0] CRD_IM_LO = W'(-3 * ONE / 8);
  localparam logic signed [W-1:0] CRD_IM_HI = W'(3 * ONE / 8);
  localparam logic signed [W-1:0] BLB_RE_LO = W'(-9 * ONE / 8);
  localparam logic signed [W-1:0] BLB_RE_HI = W'(-7 * ONE / 8);
  localparam logic signed [W-1:0] BLB_IM_LO = W'(-ONE / 8);
  localparam logic signed [W-1:0] BLB_IM_HI = W'(ONE / 8);
  localparam logic [SW:0]         ESC_LIM   = (SW + 1)'(1) << (FRAC + 2);
  localparam logic [CW-1:0]       CNT_MAX   = CW'(MAX_ITER);

  core_state_e          st;
  logic signed [W-1:0]  zr, zi, zri;
  logic signed [SW-1:0] zr2, zi2;
  logic [CW-1:0]        cnt;

  // two shared multipliers: A squares zr in C2, forms zr*zi in C3
  logic signed [W-1:0]   mul_y;
  logic signed [2*W-1:0] prod_a, prod_b;
  logic signed [SW-1:0]  sq_a, sq_b;
  logic signed [W-1:0]   xprod;
  logic                  unused_lo;

  assign mul_y     = (st == CS_C3) ? zi : zr;
  assign prod_a    = zr * mul_y;
  assign prod_b    = zi * zi;
  assign sq_a      = prod_a[2*W-1:FRAC];
  assign sq_b      = prod_b[2*W-1:FRAC];
  assign xprod     = prod_a[FRAC+W-1:FRAC];
  assign unused_lo = ^{prod_a[FRAC-1:0], prod_b[FRAC-1:0]};

  // C1 arithmetic
  logic [SW:0]          mag;
  logic                 escaped, in_box;
  logic signed [SW-1:0] zr_sum;
  logic signed [W-1:0]  zr_n, zi_n;

  assign mag     = {1'b0, zr2} + {1'b0, zi2};
  assign escaped = mag > ESC_LIM;
  assign in_box  = ((cr >= CRD_RE_LO) && (cr <= CRD_RE_HI) &&
                    (ci >= CRD_IM_LO) && (ci <= CRD_IM_HI)) ||
                   ((cr >= BLB_RE_LO) && (cr <= BLB_RE_HI) &&
                    (ci >= BLB_IM_LO) && (ci <= BLB_IM_HI));
  assign zr_sum  = zr2 - zi2 + $signed({{(SW - W){cr[W-1]}}, cr});
  assign zr_n    = zr_sum[W-1:0];
  assign zi_n    = (zri <<< 1) + ci;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= CS_IDLE;
      res_valid <= 1'b0;
      res_cnt   <= '0;
      zr        <= '0;
      zi        <= '0;
      zri       <= '0;
      zr2       <= '0;
      zi2       <= '0;
      cnt       <= '0;
    end else begin
      res_valid <= 1'b0;
      if (clr) begin
        st <= CS_IDLE;
      end else begin
        unique case (st)
          CS_IDLE: if (go) begin
            zr  <= '0;
            zi  <= '0;
            zri <= '0;
            zr2 <= '0;
            zi2 <= '0;
            cnt <= '0;
            st  <= CS_C1;
          end
          CS_C1: begin
            if (in_box || (cnt == CNT_MAX)) begin
              res_valid <= 1'b1;
              res_cnt   <= CNT_MAX;
              st        <= CS_IDLE;
            end else if (escaped) begin
              res_valid <= 1'b1;
              res_cnt   <= cnt;
              st        <= CS_IDLE;
            end else begin
              zr  <= zr_n;
              zi  <= zi_n;
              cnt <= cnt + 1'b1;
              st  <= CS_C2;
            end
          end
          CS_C2: begin
            zr2 <= sq_a;
            zi2 <= sq_b;
            st  <= CS_C3;
          end
          CS_C3: begin
            zri <= xprod;
            st  <= CS_C1;
          end
          default: st <= CS_IDLE;
        endcase
      end
    end
  end

  // R5: a reported count never passes the iteration cap
  p_cnt_cap_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_cnt <= CNT_MAX));

  // R6: a rectangle hit ends the pixel on the next edge with the cap value
  p_box_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (st == CS_C1 && in_box && !clr) |=> (res_valid && res_cnt == CNT_MAX));

  // R2: one result pulse per pixel
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

endmodule

// File: rtl/mandel_result_ram.sv
module mandel_result_ram #(
  parameter int DEPTH = 4096,
  parameter int CW    = 10,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] rdata
);

  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mandel_solver.sv
module mandel_solver
  import mandel_pkg::*;
#(
  parameter int W         = 27,
  parameter int FRAC      = 23,
  parameter int H_RES     = 640,
  parameter int V_RES     = 480,
  parameter int MAX_ITER  = 1000,
  parameter int IDW       = 8,
  parameter int MEM_DEPTH = 4096,
  localparam int CW       = $clog2(MAX_ITER + 1),
  localparam int AW       = $clog2(MEM_DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic signed [W-1:0] x0,
  input  logic signed [W-1:0] y0,
  input  logic signed [W-1:0] zoom_x,
  input  logic signed [W-1:0] zoom_y,
  input  logic [IDW-1:0]      solver_id,
  input  logic [IDW-1:0]      solver_cnt,
  input  logic [AW-1:0]       rd_addr,
  output logic [CW-1:0]       rd_data,
  output logic                done
);

  walk_state_e         ts;
  logic [AW-1:0]       waddr;
  logic signed [W-1:0] cr, ci;
  logic                owned, last, adv, core_go, res_valid, wr_en;
  logic [CW-1:0]       res_cnt;

  assign core_go = !start && (ts == TS_SCAN) && owned;
  assign wr_en   = !start && (ts == TS_WAIT) && res_valid;
  assign adv     = !start && (((ts == TS_SCAN) && !owned) || wr_en);

  mandel_coord_walk #(.W(W), .H_RES(H_RES), .V_RES(V_RES), .IDW(IDW)) u_walk (
    .clk(clk), .rst(rst), .load(start), .adv(adv),
    .x0(x0), .y0(y0), .zoom_x(zoom_x), .zoom_y(zoom_y),
    .sid(solver_id), .scnt(solver_cnt),
    .cr(cr), .ci(ci), .owned(owned), .last(last)
  );

  mandel_iter_core #(.W(W), .FRAC(FRAC), .MAX_ITER(MAX_ITER), .CW(CW)) u_core (
    .clk(clk), .rst(rst), .clr(start), .go(core_go),
    .cr(cr), .ci(ci), .res_valid(res_valid), .res_cnt(res_cnt)
  );

  mandel_result_ram #(.DEPTH(MEM_DEPTH), .CW(CW), .AW(AW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(waddr), .wdata(res_cnt),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ts    <= TS_IDLE;
      waddr <= '0;
      done  <= 1'b0;
    end else if (start) begin
      ts    <= TS_SCAN;
      waddr <= '0;
      done  <= 1'b0;
    end else begin
      unique case (ts)
        TS_SCAN: begin
          if (owned) begin
            ts <= TS_WAIT;
          end else if (last) begin
            ts   <= TS_DONE;
            done <= 1'b1;
          end
        end
        TS_WAIT: if (res_valid) begin
          waddr <= waddr + 1'b1;
          if (last) begin
            ts   <= TS_DONE;
            done <= 1'b1;
          end else begin
            ts <= TS_SCAN;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: results are packed at consecutive addresses
  p_seq_addr_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (waddr == AW'($past(waddr) + 1'b1)));

  // R7: nothing is written once the frame is finished
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_en);

  // R1: a start restarts the frame bookkeeping
  p_start_clears_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && waddr == '0));

endmodule

// File: tb/mandel_solver_bench.sv
module mandel_solver_bench;

  localparam int W     = 27;
  localparam int FRAC  = 23;
  localparam int H     = 16;
  localparam int V     = 12;
  localparam int MI    = 64;
  localparam int IDW   = 4;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(MI + 1);
  localparam longint ONE = longint'(1) << FRAC;

  logic                clk = 1'b0;
  logic                rst, start, done;
  logic signed [W-1:0] x0, y0, zoom_x, zoom_y;
  logic [IDW-1:0]      solver_id, solver_cnt;
  logic [AW-1:0]       rd_addr;
  logic [CW-1:0]       rd_data;

  int nchk  = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  mandel_solver #(.W(W), .FRAC(FRAC), .H_RES(H), .V_RES(V), .MAX_ITER(MI),
                  .IDW(IDW), .MEM_DEPTH(DEPTH)) u_mandel_solver (
    .clk(clk), .rst(rst), .start(start), .x0(x0), .y0(y0),
    .zoom_x(zoom_x), .zoom_y(zoom_y), .solver_id(solver_id),
    .solver_cnt(solver_cnt), .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint wrapw(input longint v);
    longint m;
    m = v & ((longint'(1) << W) - 1);
    if (m >= (longint'(1) << (W - 1))) m = m - (longint'(1) << W);
    return m;
  endfunction

  function automatic bit in_rect(input longint cr, input longint ci);
    return ((cr >= -ONE / 2) && (cr <= ONE / 8) &&
            (ci >= -3 * ONE / 8) && (ci <= 3 * ONE / 8)) ||
           ((cr >= -9 * ONE / 8) && (cr <= -7 * ONE / 8) &&
            (ci >= -ONE / 8) && (ci <= ONE / 8));
  endfunction

  // escape count from the requirement text (R4, R5, R6)
  function automatic longint escape_count(input longint cr, input longint ci);
    longint zr, zi, sr, si, x, k, nr, ni;
    if (in_rect(cr, ci)) return MI;
    zr = 0; zi = 0; sr = 0; si = 0; x = 0;
    for (k = 1; k <= MI; k++) begin
      nr = wrapw(sr - si + cr);
      ni = wrapw(2 * x + ci);
      zr = nr; zi = ni;
      sr = (zr * zr) >>> FRAC;
      si = (zi * zi) >>> FRAC;
      x  = wrapw((zr * zi) >>> FRAC);
      if (sr + si > 4 * ONE) return k;
    end
    return MI;
  endfunction

  task automatic run_frame(input longint ax, ay, azx, azy, input int id, n,
                           input bit disturb, output int cyc);
    @(negedge clk);
    x0 = W'(ax); y0 = W'(ay); zoom_x = W'(azx); zoom_y = W'(azy);
    solver_id = IDW'(id); solver_cnt = IDW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R7 done low after start", done, 0);
    cyc = 1;
    while (!done && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 6) begin
        x0 = ~x0; y0 = y0 + W'(ONE); zoom_x = zoom_x + W'(ONE / 4);
        zoom_y = -zoom_y; solver_id = solver_id + 1'b1; solver_cnt = solver_cnt + 1'b1;
      end
    end
    chk(done == 1'b1, "R7 done reached", done, 1);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R7 done holds", done, 1);
  endtask

  task automatic verify(input longint ax, ay, azx, azy, input int id, n, input string req);
    int a;
    longint cr, ci, e;
    a = 0;
    for (int p = 0; p < H * V; p++) begin
      if (p % n == id) begin
        cr = wrapw(ax + (p % H) * azx);
        ci = wrapw(ay + (p / H) * azy);
        e  = escape_count(cr, ci);
        rd_addr = AW'(a);
        @(negedge clk);
        chk(longint'(rd_data) == e, req, rd_data, e);
        a++;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    int cyc;
    longint ax, ay, zx, zy;
    void'($urandom(32'd2024));
    rst = 1'b1; start = 1'b0; x0 = '0; y0 = '0; zoom_x = '0; zoom_y = '0;
    solver_id = '0; solver_cnt = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R7 reset state", done, 0);
    chk($bits(rd_data) == 7, "R9 result width", $bits(rd_data), 7);

    // full frame over the whole set, single worker (R3 R4 R5 R8)
    ax = -2 * ONE; ay = -9 * ONE / 8; zx = 5 * ONE / 32; zy = 3 * ONE / 16;
    run_frame(ax, ay, zx, zy, 0, 1, 1'b0, cyc);
    verify(ax, ay, zx, zy, 0, 1, "R3 R4 R5 R8 full frame");

    // inputs disturbed after start (R1), stride 3 offset 1 (R2)
    ax = -2 * ONE + longint'($urandom % 32'(ONE / 2));
    ay = -ONE - longint'($urandom % 32'(ONE / 4));
    zx = ONE / 8 + longint'($urandom % 32'(ONE / 16));
    zy = ONE / 6 + longint'($urandom % 32'(ONE / 16));
    run_frame(ax, ay, zx, zy, 1, 3, 1'b1, cyc);
    verify(ax, ay, zx, zy, 1, 3, "R1 R2 inputs held from start");

    // stride 4, last slot (R2)
    ax = -ONE - longint'($urandom % 32'(ONE));
    ay = -ONE / 2 - longint'($urandom % 32'(ONE / 2));
    zx = ONE / 10 + longint'($urandom % 32'(ONE / 8));
    zy = ONE / 12 + longint'($urandom % 32'(ONE / 8));
    run_frame(ax, ay, zx, zy, 3, 4, 1'b0, cyc);
    verify(ax, ay, zx, zy, 3, 4, "R2 R4 stride 4 slot 3");

    // stride 5, negative vertical step (R3)
    ax = -ONE / 2 + longint'($urandom % 32'(ONE / 4));
    ay = ONE;
    zx = -(ONE / 20);
    zy = -(ONE / 7);
    run_frame(ax, ay, zx, zy, 4, 5, 1'b0, cyc);
    verify(ax, ay, zx, zy, 4, 5, "R3 R5 negative steps");

    // cardioid rectangle corner, inclusive (R6)
    run_frame(-ONE / 2, 3 * ONE / 8, 0, 0, 0, 1, 1'b0, cyc);
    chk(cyc < H * V * 5, "R6 cardioid corner fast", cyc, H * V * 5);
    verify(-ONE / 2, 3 * ONE / 8, 0, 0, 0, 1, "R6 cardioid corner count");

    // bulb rectangle corner, inclusive (R6)
    run_frame(-9 * ONE / 8, -ONE / 8, 0, 0, 0, 1, 1'b0, cyc);
    chk(cyc < H * V * 5, "R6 bulb corner fast", cyc, H * V * 5);
    verify(-9 * ONE / 8, -ONE / 8, 0, 0, 0, 2, "R6 bulb corner count");

    // one step outside the cardioid rectangle: iterates to the cap (R6 R5)
    run_frame(ONE / 8 + 1, 0, 0, 0, 0, 1, 1'b0, cyc);
    chk(cyc > H * V * 100, "R6 outside rectangle iterates", cyc, H * V * 100);
    verify(ONE / 8 + 1, 0, 0, 0, 0, 1, "R5 cap reached outside rectangle");

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule